// File: doc/BRIEF.md
# Way-Predicted Set-Associative Tag Lookup

This block is the lookup front end of a set-associative cache that guesses which way a request will hit before it reads any tag. A per-set prediction table names one way. In the first lookup cycle only that way's tag sub-array is enabled and compared. When the guess is right, the second cycle enables only the matching way's data sub-array and the access completes. When the guess is wrong, an extra cycle enables every tag sub-array. A match found in that cycle is still a hit: the data sub-array of the matching way is read next, and the prediction entry is retrained to that way. If nothing matches, a miss is reported.

Requests use a valid/ready handshake, and only one request is in flight at a time. Each response reports hit or miss, the way, the data and the lookup latency. The per-way tag and data read enables are brought out as ports, so that the access pattern, and with it the energy the prediction saves, can be seen. A refill-write port installs a tag and a data word into a chosen way and points that set's prediction at the way. Choosing the victim and fetching from memory are left to the logic around the block.

Top module: `wp_tag_lookup`

## Requirements
- R1: In the cycle after a request is accepted, `tag_rd_en` has exactly one bit set, at the position of the way currently predicted for the requested set.
- R2: A tag match in the predicted way is a hit with no all-ways tag cycle. `tag_rd_en` is zero in the following cycle, and the response reports `rsp_hit`=1, that way, and `rsp_lat`=2.
- R3: On a hit, in the cycle after the tag match `data_rd_en` has exactly one bit set, at the hit way. The response then returns the data last written to that way and set.
- R4: When the predicted way does not match, the next cycle sets every bit of `tag_rd_en`, holds `req_ready` low and produces no response.
- R5: A miss is reported only when no valid way of the set matches in the all-ways cycle. The response is `rsp_hit`=0, `rsp_lat`=2 and `rsp_data`=0, and it appears in the cycle after the all-ways check.
- R6: A hit found in the all-ways cycle reports `rsp_lat`=3 and the way that matched.
- R7: Every prediction entry resets to way 0. An entry is rewritten with the matching way after a hit found in the all-ways cycle. A predicted-way hit or a miss leaves it unchanged.
- R8: Reset clears every tag valid bit. An entry that is not valid never matches, whatever tag it holds.
- R9: A refill write (`fill_valid`=1) stores the tag and data into way `fill_way` of set `fill_idx` and marks the entry valid. It also sets that set's prediction to `fill_way`. If it coincides with a retraining update to the same set, the refill wins.
- R10: `req_ready` is high only when no request is in flight. `rsp_valid` is a one-cycle pulse, and `req_ready` is high again in the cycle of that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, can accept a request |
| req_idx | input | IDX_W | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| fill_valid | input | 1 | Refill write strobe |
| fill_idx | input | IDX_W | Set written by the refill |
| fill_way | input | WAY_W | Way written by the refill |
| fill_tag | input | TAG_W | Tag installed by the refill |
| fill_data | input | DATA_W | Data installed by the refill |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | WAY_W | Way that hit (0 on a miss) |
| rsp_lat | output | 2 | Lookup cycles: 2 for a predicted hit or a miss, 3 for a mispredicted hit |
| rsp_data | output | DATA_W | Data of the hit way (0 on a miss) |
| tag_rd_en | output | WAYS | Per-way tag sub-array read enable |
| data_rd_en | output | WAYS | Per-way data sub-array read enable |

## Verification
Some properties are checked on every cycle by the assertions. The first probe after an accept enables a single tag sub-array. The all-ways cycle only ever follows a mismatch in the predicted way. A data sub-array is enabled only if its tag matched in the cycle before. A miss is reported only after a full tag check that found nothing. Each latency code agrees with the enable pattern that preceded it. A prediction entry takes the way of the last all-ways hit or the last refill. Other behaviour shows only in the bench's sweeps, which walk every way of every set through predicted and mispredicted lookups. They cover correct data return, the predictor's sequence of states across lookups, invalid entries after reset never matching, and overwriting an existing entry.

// File: rtl/wpl_pkg.sv
// Package: shared state encoding and latency codes for the way-predicted
// lookup. Assumes nothing beyond a two-bit latency field.
package wpl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_ALL   = 2'd2,
        ST_DATA  = 2'd3
    } lk_state_t;

    localparam logic [1:0] LAT_FAST = 2'd2;
    localparam logic [1:0] LAT_SLOW = 2'd3;

endpackage

// File: rtl/wpl_tag_store.sv
// Module: per-way tag sub-arrays with valid bits and comparators.
// Each way compares only when its read enable is set, so a disabled way
// can never report a match. Assumes a single write port shared by all ways.
module wpl_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 6,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]  match,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld;

        // Install a tag and set its valid bit; reset invalidates the way.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
            end else if (wr_en && (wr_way == WAY_W'(w))) begin
                vld[wr_idx]     <= 1'b1;
                tag_mem[wr_idx] <= wr_tag;
            end
        end

        // Enabled, valid and equal tag gives a match for this way.
        assign match[w] = rd_en[w] && vld[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    end

endmodule

// File: rtl/wpl_data_store.sv
// Module: per-way data sub-arrays. Only enabled ways drive the read
// result; the enables are expected to be one-hot or zero. No reset on
// storage: a word is only read after it has been written.
module wpl_data_store #(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(SETS),
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic [WAYS-1:0]   rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] way_out [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem [SETS];

        // Refill write into this way.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(w))) begin
                mem[wr_idx] <= wr_data;
            end
        end

        assign way_out[w] = mem[rd_idx];
    end

    // Merge the enabled ways' words into one read result.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_en[w]) begin
                rd_data = rd_data | way_out[w];
            end
        end
    end

endmodule

// File: rtl/wpl_pred_table.sv
// Module: one predicted-way entry per set. A refill takes priority over a
// retraining update in the same cycle. Assumes asynchronous read.
module wpl_pred_table #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [WAY_W-1:0] fill_way
);

    logic [WAY_W-1:0] pred [SETS];

    // Reset to way 0; refill first, otherwise retrain from an all-ways hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                pred[s] <= '0;
            end
        end else if (fill_en) begin
            pred[fill_idx] <= fill_way;
        end else if (upd_en) begin
            pred[upd_idx] <= upd_way;
        end
    end

    assign rd_way = pred[rd_idx];

    AST_PRED_RETRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !fill_en) |=> (pred[$past(upd_idx)] == $past(upd_way))); // R7

    AST_PRED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (pred[$past(fill_idx)] == $past(fill_way))); // R9

endmodule

// File: rtl/wpl_ctrl.sv
// Module: lookup sequencer. It handles one request at a time: a
// predicted-way probe, an optional all-ways probe, a single-way data read,
// then a registered response. It assumes the tag store gates matches with
// the read enables it drives.
module wpl_ctrl
    import wpl_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [TAG_W-1:0]  req_tag,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic [WAY_W-1:0]  pred_way,
    input  logic [WAYS-1:0]   tag_match,
    output logic [WAYS-1:0]   tag_rd_en,
    output logic [WAYS-1:0]   data_rd_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic              upd_en,
    output logic [WAY_W-1:0]  upd_way,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [1:0]        rsp_lat,
    output logic [DATA_W-1:0] rsp_data
);

    lk_state_t         state;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WAY_W-1:0]  way_q;
    logic              slow_q;
    logic [WAY_W-1:0]  found_way;

    assign req_ready = (state == ST_IDLE);
    assign lk_idx    = idx_q;
    assign lk_tag    = tag_q;
    assign upd_way   = found_way;

    // Encode the lowest matching way.
    always_comb begin
        found_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (tag_match[w]) begin
                found_way = WAY_W'(w);
            end
        end
    end

    // Sub-array enables and predictor retrain strobe, by state.
    always_comb begin
        tag_rd_en  = '0;
        data_rd_en = '0;
        upd_en     = 1'b0;
        case (state)
            ST_PROBE: tag_rd_en[pred_way] = 1'b1;
            ST_ALL: begin
                tag_rd_en = '1;
                upd_en    = |tag_match;
            end
            ST_DATA:  data_rd_en[way_q] = 1'b1;
            default: ;
        endcase
    end

    // State sequence, request capture and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx_q     <= '0;
            tag_q     <= '0;
            way_q     <= '0;
            slow_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_lat   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q  <= req_idx;
                        tag_q  <= req_tag;
                        slow_q <= 1'b0;
                        state  <= ST_PROBE;
                    end
                end
                ST_PROBE: begin
                    if (|tag_match) begin
                        way_q <= pred_way;
                        state <= ST_DATA;
                    end else begin
                        state <= ST_ALL;
                    end
                end
                ST_ALL: begin
                    if (|tag_match) begin
                        way_q  <= found_way;
                        slow_q <= 1'b1;
                        state  <= ST_DATA;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_way   <= '0;
                        rsp_lat   <= LAT_FAST;
                        rsp_data  <= '0;
                        state     <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_way   <= way_q;
                    rsp_lat   <= slow_q ? LAT_SLOW : LAT_FAST;
                    rsp_data  <= rd_data;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ($countones(tag_rd_en) == 1)); // R1

    AST_FAST_HIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_lat == LAT_FAST)
            |-> ($past(data_rd_en) != '0 && $countones($past(tag_rd_en, 2)) == 1)); // R2

    AST_DATA_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_en != '0) |-> (($past(tag_match) & data_rd_en) != '0)); // R3

    AST_ALL_ONLY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_rd_en == '1 && WAYS > 1)
            |-> ($past(tag_rd_en) != '0 && $past(tag_match) == '0 && !req_ready)); // R4

    AST_MISS_FULL_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> ($past(tag_rd_en) == '1 && $past(tag_match) == '0)); // R5

    AST_SLOW_HIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && rsp_lat == LAT_SLOW) |-> ($past(tag_rd_en, 2) == '1)); // R6

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && !$past(rsp_valid))); // R10

endmodule

// File: rtl/wp_tag_lookup.sv
// Module: top of the way-predicted lookup. It connects the prediction
// table, the tag and data sub-arrays and the sequencer. It assumes that
// refill writes are issued by outside logic that chooses the victim way.
module wp_tag_lookup #(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [1:0]        rsp_lat,
    output logic [DATA_W-1:0] rsp_data,
    output logic [WAYS-1:0]   tag_rd_en,
    output logic [WAYS-1:0]   data_rd_en
);

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WAY_W-1:0]  pred_way;
    logic [WAYS-1:0]   tag_match;
    logic [DATA_W-1:0] rd_data;
    logic              upd_en;
    logic [WAY_W-1:0]  upd_way;

    wpl_pred_table #(.SETS(SETS), .WAYS(WAYS)) u_pred (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_way(pred_way),
        .upd_en(upd_en), .upd_idx(lk_idx), .upd_way(upd_way),
        .fill_en(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way)
    );

    wpl_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_en(tag_rd_en), .rd_idx(lk_idx), .rd_tag(lk_tag), .match(tag_match),
        .wr_en(fill_valid), .wr_idx(fill_idx), .wr_way(fill_way), .wr_tag(fill_tag)
    );

    wpl_data_store #(.WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_en(data_rd_en), .rd_idx(lk_idx), .rd_data(rd_data),
        .wr_en(fill_valid), .wr_idx(fill_idx), .wr_way(fill_way), .wr_data(fill_data)
    );

    wpl_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
               .IDX_W(IDX_W), .WAY_W(WAY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_tag(req_tag),
        .lk_idx(lk_idx), .lk_tag(lk_tag),
        .pred_way(pred_way), .tag_match(tag_match),
        .tag_rd_en(tag_rd_en), .data_rd_en(data_rd_en), .rd_data(rd_data),
        .upd_en(upd_en), .upd_way(upd_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_lat(rsp_lat), .rsp_data(rsp_data)
    );

    AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (tag_match == '0)); // R8

endmodule

// File: tb/wp_tag_lookup_bench.sv
// Bench: sweeps every way of every set through predicted and mispredicted
// lookups. It keeps its own model of tags, data and predictions.
module wp_tag_lookup_bench;

    localparam int WAYS = 4, SETS = 8, TAG_W = 6, DATA_W = 16;
    localparam int IDX_W = 3, WAY_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IDX_W-1:0]  req_idx = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              fill_valid = 1'b0;
    logic [IDX_W-1:0]  fill_idx = '0;
    logic [WAY_W-1:0]  fill_way = '0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              rsp_valid, rsp_hit;
    logic [WAY_W-1:0]  rsp_way;
    logic [1:0]        rsp_lat;
    logic [DATA_W-1:0] rsp_data;
    logic [WAYS-1:0]   tag_rd_en, data_rd_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int mt [SETS][WAYS];
    bit mv [SETS][WAYS];
    int md [SETS][WAYS];
    int mp [SETS];

    always #10 clk = ~clk;

    wp_tag_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wp_tag_lookup (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx), .req_tag(req_tag),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_lat(rsp_lat), .rsp_data(rsp_data),
        .tag_rd_en(tag_rd_en), .data_rd_en(data_rd_en)
    );

    function automatic int dval(int s, int w, int t);
        return (t * 97 + s * 13 + w * 5 + 1) % 65536;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_fill(input int s, input int w, input int t);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_idx   = IDX_W'(s);
        fill_way   = WAY_W'(w);
        fill_tag   = TAG_W'(t);
        fill_data  = DATA_W'(dval(s, w, t));
        @(negedge clk);
        fill_valid = 1'b0;
        mt[s][w] = t; mv[s][w] = 1'b1; md[s][w] = dval(s, w, t); mp[s] = w;
    endtask

    task automatic do_lookup(input int s, input int t);
        int hw;
        hw = -1;
        for (int w = 0; w < WAYS; w++) begin
            if (mv[s][w] && mt[s][w] == t) hw = w;
        end
        @(negedge clk);
        chk("R10", "ready when idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_idx   = IDX_W'(s);
        req_tag   = TAG_W'(t);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "first probe enables", int'(tag_rd_en), 1 << mp[s]);
        chk("R10", "ready while busy", int'(req_ready), 0);
        if (hw == mp[s]) begin
            @(negedge clk);
            chk("R3", "data enable predicted", int'(data_rd_en), 1 << hw);
            chk("R2", "no extra tag probe", int'(tag_rd_en), 0);
            @(negedge clk);
            chk("R2", "fast hit valid", int'(rsp_valid), 1);
            chk("R2", "fast hit flag", int'(rsp_hit), 1);
            chk("R2", "fast hit way", int'(rsp_way), hw);
            chk("R2", "fast latency", int'(rsp_lat), 2);
            chk("R3", "fast data", int'(rsp_data), md[s][hw]);
            chk("R10", "ready with response", int'(req_ready), 1);
        end else begin
            @(negedge clk);
            chk("R4", "all tags enabled", int'(tag_rd_en), (1 << WAYS) - 1);
            chk("R4", "ready low in extra cycle", int'(req_ready), 0);
            chk("R4", "no response in extra cycle", int'(rsp_valid), 0);
            if (hw >= 0) begin
                @(negedge clk);
                chk("R3", "data enable after all-ways", int'(data_rd_en), 1 << hw);
                @(negedge clk);
                chk("R6", "slow hit valid", int'(rsp_valid), 1);
                chk("R6", "slow hit flag", int'(rsp_hit), 1);
                chk("R6", "slow hit way", int'(rsp_way), hw);
                chk("R6", "slow latency", int'(rsp_lat), 3);
                chk("R3", "slow data", int'(rsp_data), md[s][hw]);
                mp[s] = hw;
            end else begin
                @(negedge clk);
                chk("R5", "miss valid", int'(rsp_valid), 1);
                chk("R5", "miss flag", int'(rsp_hit), 0);
                chk("R5", "miss latency", int'(rsp_lat), 2);
                chk("R5", "miss data", int'(rsp_data), 0);
            end
        end
        @(negedge clk);
        chk("R10", "response is a pulse", int'(rsp_valid), 0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mp[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                mt[s][w] = 0; mv[s][w] = 1'b0; md[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        chk("R10", "ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "no response after reset", int'(rsp_valid), 0);
        chk("R1", "no tag read when idle", int'(tag_rd_en), 0);

        // R8: nothing valid after reset, so every set misses (R7: way 0 predicted).
        for (int s = 0; s < SETS; s++) begin
            do_lookup(s, 0);
            do_lookup(s, 5);
        end

        // R9: fill every way of every set with distinct tags.
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                do_fill(s, w, s * WAYS + w + 1);
            end
        end

        // Every way twice: first mispredicted unless predicted, then predicted.
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                do_lookup(s, s * WAYS + w + 1);
                do_lookup(s, s * WAYS + w + 1);
            end
            do_lookup(s, 63);
            do_lookup(s, (s * WAYS + 1));
        end

        // R9: overwrite an entry; the new tag hits predicted, the old tag misses.
        do_fill(2, 1, 50);
        do_lookup(2, 50);
        do_lookup(2, 2 * WAYS + 2);
        do_lookup(2, 2 * WAYS + 4);
        do_lookup(2, 50);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule